// File: doc/BRIEF.md
# Page Write Collector with Self-Timed Program Cycle

This block sits behind the serial command front end of a byte-addressed non-volatile store. Once a write command has been decoded, it is handed a start address and then one data byte at a time. It keeps these bytes in a one-page staging buffer. When chip select is released it decides whether the transfer ended cleanly. If it did, it runs a fixed-length program cycle, and during that cycle it copies the staged bytes into the array through a simple write port.

The page size is 128 bytes. Only the low seven address bits advance from byte to byte, so a long burst folds back onto the start of its own page and overwrites the bytes sent earlier. Each byte arrives with a protection flag computed by a neighbouring block from the address shown on `next_addr_o`. A protected byte is kept in the buffer but is never written, while the unprotected bytes of the same page are still committed. Array locations that received no byte keep their old contents.

While the program cycle runs, `busy_o` is high. The block ignores every new start, byte and chip-select event during that time. The command decoder uses `busy_o` to allow only status reads.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_we_o` are 0.
- R2: A start with `wel_i`=1 loads `next_addr_o` with the start address. Each accepted byte adds one to bits [6:0] only, going from 127 back to 0, and bits [15:7] never change.
- R3: When more than 128 bytes are received, a page slot that is hit more than once is committed with the last byte sent to it.
- R4: A program cycle starts only if `cs_rise_i` arrives while collecting, with `bit_aligned_i`=1, and with at least one byte received. Otherwise the transfer is dropped, and there is no busy period and no array write.
- R5: A start with `wel_i`=0 is ignored: the bytes that follow are not collected and the chip-select rise starts no program cycle.
- R6: `busy_o` rises in the cycle after the accepted `cs_rise_i` and stays high for exactly TWC_CYC cycles.
- R7: While `busy_o` is 1, `start_i`, `byte_vld_i` and `cs_rise_i` have no effect. The page bits of `next_addr_o` are unchanged, no extra write occurs, and no second busy period follows.
- R8: During the program cycle, each received slot is written exactly once, at address {page bits, slot}, with its stored data, in ascending slot order. Slots that were not received are not written.
- R9: A byte whose `byte_prot_i` was 1 when it was accepted is not written. The other bytes of the page are written.
- R10: `done_o` is high for one cycle, which is the last busy cycle. `busy_o` is 0 in the cycle after it.
- R11: `mem_we_o` is only ever 1 while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Write command decoded, start address valid |
| start_addr_i | input | 16 | First byte address |
| wel_i | input | 1 | Write-enable latch state at start |
| byte_vld_i | input | 1 | One data byte received |
| byte_i | input | 8 | Received data byte |
| byte_prot_i | input | 1 | Current address lies in a protected region |
| cs_rise_i | input | 1 | Chip select released (one-cycle event) |
| bit_aligned_i | input | 1 | Serial bit counter at a byte boundary |
| next_addr_o | output | 16 | Address the next byte will take |
| busy_o | output | 1 | Program cycle in progress |
| done_o | output | 1 | Last cycle of the program cycle |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 16 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The assertions check on every cycle that array writes occur only while busy, that every busy period follows a chip-select rise, lasts exactly TWC_CYC cycles and ends with a single done pulse, and that the page bits of the address counter change only on a start. Data-dependent outcomes need the bench's scenarios, because only a comparison of the written addresses and data with a model can show them. These outcomes are: page folding and overwrite, per-byte protection, untouched slots, and the dropping of misaligned, empty or not-enabled transfers.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_FILL = 2'd1,
        PW_PROG = 2'd2
    } pw_state_e;

    typedef struct packed {
        logic       vld;
        logic       prot;
        logic [7:0] data;
    } pw_slot_t;

    function automatic logic commit_ok(input logic aligned, input logic have_bytes);
        return aligned & have_bytes;
    endfunction

    function automatic logic slot_writes(input pw_slot_t s);
        return s.vld & ~s.prot;
    endfunction

endpackage

// File: rtl/pwb_addr_ctr.sv
module pwb_addr_ctr #(
    parameter int AW  = 16,
    parameter int SAW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] load_addr_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= load_addr_i;
        end else if (step_i) begin
            addr_q <= {addr_q[AW-1:SAW], addr_q[SAW-1:0] + SAW'(1)};
        end
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/pwb_page_buf.sv
module pwb_page_buf
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int SAW        = $clog2(PAGE_BYTES)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_i,
    input  logic           we_i,
    input  logic [SAW-1:0] waddr_i,
    input  pw_slot_t       wentry_i,
    input  logic [SAW-1:0] raddr_i,
    output pw_slot_t       rentry_o,
    output logic           any_o
);
    pw_slot_t slots [PAGE_BYTES];
    logic     any_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                slots[g] <= '0;
            end else if (we_i && (waddr_i == SAW'(g))) begin
                slots[g] <= wentry_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            any_q <= 1'b0;
        end else if (we_i) begin
            any_q <= 1'b1;
        end
    end

    assign rentry_o = slots[raddr_i];
    assign any_o    = any_q;
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
    parameter int TWC_CYC = 200,
    parameter int TW      = $clog2(TWC_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic run_i,
    output logic expire_o
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= TW'(TWC_CYC - 1);
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer
    import pwb_pkg::*;
#(
    parameter int AW         = 16,
    parameter int PAGE_BYTES = 128,
    parameter int TWC_CYC    = 200
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic          wel_i,
    input  logic          byte_vld_i,
    input  logic [7:0]    byte_i,
    input  logic          byte_prot_i,
    input  logic          cs_rise_i,
    input  logic          bit_aligned_i,
    output logic [AW-1:0] next_addr_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [7:0]    mem_wdata_o
);
    localparam int SAW = $clog2(PAGE_BYTES);

    pw_state_e      st_q, st_d;
    logic [AW-1:0]  addr_q;
    logic           addr_load, fill_byte, commit;
    logic           buf_any, tmr_expire;
    logic [SAW:0]   scan_q;
    pw_slot_t       wentry, rentry;

    assign addr_load = (st_q == PW_IDLE) && start_i && wel_i;
    assign fill_byte = (st_q == PW_FILL) && byte_vld_i;
    assign commit    = (st_q == PW_FILL) && cs_rise_i &&
                       commit_ok(bit_aligned_i, buf_any | byte_vld_i);

    assign wentry = '{vld: 1'b1, prot: byte_prot_i, data: byte_i};

    pwb_addr_ctr #(.AW(AW), .SAW(SAW)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .load_i      (addr_load),
        .load_addr_i (start_addr_i),
        .step_i      (fill_byte),
        .addr_o      (addr_q)
    );

    pwb_page_buf #(.PAGE_BYTES(PAGE_BYTES), .SAW(SAW)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (addr_load),
        .we_i     (fill_byte),
        .waddr_i  (addr_q[SAW-1:0]),
        .wentry_i (wentry),
        .raddr_i  (scan_q[SAW-1:0]),
        .rentry_o (rentry),
        .any_o    (buf_any)
    );

    pwb_cycle_timer #(.TWC_CYC(TWC_CYC)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load_i   (commit),
        .run_i    (st_q == PW_PROG),
        .expire_o (tmr_expire)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PW_IDLE: if (addr_load) st_d = PW_FILL;
            PW_FILL: if (cs_rise_i) st_d = commit ? PW_PROG : PW_IDLE;
            PW_PROG: if (tmr_expire) st_d = PW_IDLE;
            default: st_d = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= PW_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q <= '0;
        end else if (commit) begin
            scan_q <= '0;
        end else if ((st_q == PW_PROG) && !scan_q[SAW]) begin
            scan_q <= scan_q + (SAW+1)'(1);
        end
    end

    assign next_addr_o = addr_q;
    assign busy_o      = (st_q == PW_PROG);
    assign done_o      = (st_q == PW_PROG) && tmr_expire;
    assign mem_we_o    = (st_q == PW_PROG) && !scan_q[SAW] && slot_writes(rentry);
    assign mem_addr_o  = {addr_q[AW-1:SAW], scan_q[SAW-1:0]};
    assign mem_wdata_o = rentry.data;
endmodule

// File: rtl/pwb_page_writer_chk.sv
module pwb_page_writer_chk #(
    parameter int AW         = 16,
    parameter int PAGE_BYTES = 128,
    parameter int TWC_CYC    = 200
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          cs_rise_i,
    input logic [AW-1:0] next_addr_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          mem_we_o
);
    localparam int SAW = $clog2(PAGE_BYTES);
    localparam int CW  = $clog2(TWC_CYC + 2);

    logic [CW-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) begin
            busy_len <= '0;
        end else begin
            busy_len <= busy_len + CW'(1);
        end
    end

    assert_we_in_busy_R11: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> busy_o);

    assert_busy_after_cs_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(cs_rise_i));

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (busy_len == CW'(TWC_CYC)));

    assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);

    assert_done_ends_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    assert_page_fixed_R2: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(next_addr_o[AW-1:SAW]));
endmodule

bind pwb_page_writer pwb_page_writer_chk #(
    .AW(AW), .PAGE_BYTES(PAGE_BYTES), .TWC_CYC(TWC_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .cs_rise_i   (cs_rise_i),
    .next_addr_o (next_addr_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_we_o    (mem_we_o)
);

// File: tb/tb_pwb_page_writer.sv
module tb_pwb_page_writer;
    localparam int AW   = 16;
    localparam int PAGE = 128;
    localparam int SAW  = 7;
    localparam int TWC  = 200;
    localparam int MAXCYC = 150000;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i = 0, wel_i = 0, byte_vld_i = 0, byte_prot_i = 0;
    logic          cs_rise_i = 0, bit_aligned_i = 0;
    logic [AW-1:0] start_addr_i = '0;
    logic [7:0]    byte_i = '0;
    logic [AW-1:0] next_addr_o, mem_addr_o;
    logic          busy_o, done_o, mem_we_o;
    logic [7:0]    mem_wdata_o;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    bit [7:0]      expd [PAGE];
    bit            expv [PAGE];
    bit            expp [PAGE];
    logic [AW-1:0] oa [$];
    logic [7:0]    od [$];

    always #2 clk = ~clk;

    pwb_page_writer #(.AW(AW), .PAGE_BYTES(PAGE), .TWC_CYC(TWC)) dut (.*);

    always @(negedge clk) begin
        if (!rst && mem_we_o) begin
            oa.push_back(mem_addr_o);
            od.push_back(mem_wdata_o);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
        return {a[AW-1:SAW], a[SAW-1:0] + 7'd1};
    endfunction

    // One full transfer; thr = first protected slot (PAGE means none)
    task automatic txn(input logic [AW-1:0] a, input int n, input bit wel,
                       input bit aligned, input int thr, input bit noisy, input string req);
        logic [AW-1:0] cur;
        logic [AW-1:0] page_before;
        bit   accept;
        int   nb, ndone, nexp;
        for (int s = 0; s < PAGE; s++) begin expv[s] = 0; expp[s] = 0; expd[s] = 0; end
        oa.delete(); od.delete();
        start_i = 1; start_addr_i = a; wel_i = wel;
        @(negedge clk);
        start_i = 0; wel_i = $urandom_range(0, 1);
        if (wel) check(next_addr_o == a, "R2", "start address", next_addr_o, a);
        cur = a;
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 3) == 0) @(negedge clk);
            byte_vld_i = 1; byte_i = 8'($urandom);
            byte_prot_i = (int'(cur[SAW-1:0]) >= thr);
            if (wel) begin
                expd[cur[SAW-1:0]] = byte_i;
                expv[cur[SAW-1:0]] = 1;
                expp[cur[SAW-1:0]] = byte_prot_i;
            end
            @(negedge clk);
            byte_vld_i = 0;
            cur = bump(cur);
        end
        if (wel && n > 0) check(next_addr_o == cur, "R2", "address after bytes", next_addr_o, cur);
        cs_rise_i = 1; bit_aligned_i = aligned;
        @(negedge clk);
        cs_rise_i = 0; bit_aligned_i = 0;
        accept = wel && aligned && (n > 0);
        page_before = next_addr_o;
        nb = 0; ndone = 0;
        while (busy_o && nb < TWC + 10) begin
            if (done_o) begin
                ndone++;
                check(nb == TWC - 1, "R10", "done position", nb, TWC - 1);
            end
            if (noisy) begin
                start_i = $urandom_range(0, 1); wel_i = 1; start_addr_i = 16'($urandom);
                byte_vld_i = $urandom_range(0, 1); byte_i = 8'($urandom); byte_prot_i = 0;
                cs_rise_i = $urandom_range(0, 1); bit_aligned_i = 1;
            end
            nb++;
            @(negedge clk);
        end
        start_i = 0; wel_i = 0; byte_vld_i = 0; cs_rise_i = 0; bit_aligned_i = 0;
        check(nb == (accept ? TWC : 0), accept ? "R6" : (wel ? "R4" : "R5"),
              {req, " busy length"}, nb, accept ? TWC : 0);
        if (accept) check(ndone == 1, "R10", "done pulses", ndone, 1);
        if (noisy) begin
            check(next_addr_o[AW-1:SAW] == page_before[AW-1:SAW], "R7", "page bits under noise",
                  next_addr_o, page_before);
            @(negedge clk);
            check(!busy_o, "R7", "no second busy", busy_o, 0);
        end
        nexp = 0;
        for (int s = 0; s < PAGE; s++) begin
            if (accept && expv[s] && !expp[s]) begin
                if (nexp < oa.size())
                    check(oa[nexp] == {a[AW-1:SAW], 7'(s)} && od[nexp] == expd[s], req,
                          "write addr/data", {oa[nexp], od[nexp]}, {a[AW-1:SAW], 7'(s), expd[s]});
                nexp++;
            end
        end
        check(oa.size() == nexp, req, "write count", oa.size(), nexp);
    endtask

    initial begin
        #(MAXCYC * 4);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        check(!busy_o && !done_o && !mem_we_o, "R1", "reset outputs",
              {busy_o, done_o, mem_we_o}, 0);
        txn(16'h1234, 4, 1, 1, PAGE, 0, "R8");
        txn(16'h0A7C, 10, 1, 1, PAGE, 0, "R2");
        txn(16'h0200, 300, 1, 1, PAGE, 0, "R3");
        txn(16'h4400, 8, 1, 0, PAGE, 0, "R4");
        txn(16'h4400, 0, 1, 1, PAGE, 0, "R4");
        txn(16'h3300, 12, 0, 1, PAGE, 0, "R5");
        txn(16'h5B3C, 10, 1, 1, 64, 0, "R9");
        txn(16'h7700, 20, 1, 1, PAGE, 1, "R7");
        for (int k = 0; k < 25; k++)
            txn(16'($urandom), $urandom_range(1, 260), $urandom_range(0, 9) != 0,
                $urandom_range(0, 6) != 0, $urandom_range(0, PAGE), $urandom_range(0, 3) == 0, "R8");
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule